// File: doc/BRIEF.md
# Quadrature Square-Wave Synthesizer with Serial Tuning-Word Divider

This block produces two square waves, `i_out` and `q_out`, at one programmable frequency, with `q_out` trailing `i_out` by a quarter period. Each wave is the top bit of its own phase accumulator, which advances once per system clock by a shared increment.

The increment is not supplied from outside. A start pulse takes a requested output frequency and the system clock frequency, and a bit-serial restoring divider turns them into `floor(tgt_freq * 2^W / clk_freq)`. When the divider finishes, both accumulators are loaded and frozen, and `ready` is raised. A second start pulse releases them. The I accumulator steps from the first edge after the release. The Q accumulator steps a fixed number of cycles later, and its load value is advanced to make up for the late start. Once both are running, the phase gap is exactly a quarter turn.

Requests at or above a quarter of the clock frequency are refused, because a quarter period would then be shorter than one clock. A clock frequency of zero is refused as well. Both cases raise `err`, and the outputs stay stopped.

Top module: `quad_nco`

## Requirements
- R1: After reset, `i_out`, `q_out`, `busy`, `ready` and `err` are all low.
- R2: A start pulse with valid operands, given while neither `busy` nor `ready` is high, raises `busy` at the next edge. `busy` stays high for exactly 32 cycles, and `ready` rises as `busy` falls.
- R3: A start pulse while `busy` is high is ignored. Operand changes at that moment are also ignored, and neither the busy length nor the result changes.
- R4: The per-cycle increment is `floor(tgt_freq * 2^32 / clk_freq)`, computed by 32 shift-and-subtract steps.
- R5: While `ready` is high and no start arrives, both outputs are frozen. `i_out` is 0, and `q_out` is bit 31 of `(4*inc - 0x4000_0000) mod 2^32`.
- R6: A start pulse while `ready` is high lowers `ready` and releases the accumulators. `m` edges after the release, `i_out` equals bit 31 of `m*inc`.
- R7: The Q accumulator begins stepping 4 edges after the I accumulator. `m` edges after the release, `q_out` equals bit 31 of `(4*inc - 0x4000_0000) + max(0, m-4)*inc`. Each rising edge of Q therefore follows a rising edge of I by a quarter period, within one clock.
- R8: A start pulse with `4*tgt_freq >= clk_freq` raises `err`. `busy` does not rise, and both outputs are held at 0.
- R9: A start pulse with `clk_freq == 0` raises `err` in the same way.
- R10: A start pulse while the waves are running, or after an error, stops the outputs, resets both accumulators to 0, clears `err` when the operands are valid, and begins a new calculation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Single-cycle pulse: begin a calculation, or release the loaded waves |
| tgt_freq | input | 32 | Requested output frequency, in the same unit as `clk_freq` |
| clk_freq | input | 32 | System clock frequency |
| i_out | output | 1 | In-phase square wave |
| q_out | output | 1 | Quadrature square wave, a quarter period behind `i_out` |
| busy | output | 1 | Divider is working |
| ready | output | 1 | Increment computed, accumulators loaded and frozen |
| err | output | 1 | Last start request was refused |

## Verification
The hardest situation to reach from the ports is the staggered release. For four cycles only the I accumulator moves, and the exactness of the quarter-turn gap depends on the pre-advanced Q load value being right. The stimulus releases the waves from the loaded state and compares both outputs against the closed-form phases on every cycle, starting at the release edge, for increments that range from very slow up to just below the quarter-clock limit. Requests at the exact quarter-clock boundary and with a zero clock frequency are applied to drive the refusal path. A start pulse with altered operands is injected in the middle of a calculation to show that it is ignored.

// File: rtl/qnco_pkg.sv
package qnco_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_HOLD = 2'd2,
    ST_RUN  = 2'd3
  } qnco_state_e;
endpackage

// File: rtl/qnco_div.sv
// Restoring divider, one quotient bit per cycle: quot = (num << W) / den.
// It requires num < den, so the quotient fits in W bits.
module qnco_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         last_o,
  output logic [W-1:0] quot_nxt_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  rem_q, rem_d, den_q, den_d, quot_q, quot_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic [W:0]    shifted, diff;
  logic          ge;

  always_comb begin
    shifted = {rem_q, 1'b0};
    diff    = shifted - {1'b0, den_q};
    ge      = shifted >= {1'b0, den_q};
    last_o  = run_q && (cnt_q == CW'(W-1));
    quot_nxt_o = {quot_q[W-2:0], ge};

    rem_d  = rem_q;
    den_d  = den_q;
    quot_d = quot_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    if (load) begin
      rem_d  = num;
      den_d  = den;
      quot_d = '0;
      cnt_d  = '0;
      run_d  = 1'b1;
    end else if (run_q) begin
      rem_d  = ge ? diff[W-1:0] : shifted[W-1:0];
      quot_d = quot_nxt_o;
      cnt_d  = cnt_q + 1'b1;
      run_d  = !last_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quot_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      den_q  <= den_d;
      quot_q <= quot_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
    end
  end
endmodule

// File: rtl/qnco_acc.sv
// Phase accumulator with a load port and a step enable; output is the MSB.
module qnco_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  input  logic [W-1:0] inc,
  output logic         msb_o
);
  logic [W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (load)    ph_d = load_val;
    else if (en) ph_d = ph_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign msb_o = ph_q[W-1];
endmodule

// File: rtl/quad_nco.sv
module quad_nco #(
  parameter int ACC_W = 32,
  parameter int LAG   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ACC_W-1:0] tgt_freq,
  input  logic [ACC_W-1:0] clk_freq,
  output logic             i_out,
  output logic             q_out,
  output logic             busy,
  output logic             ready,
  output logic             err
);
  import qnco_pkg::*;

  localparam logic [ACC_W-1:0] QTR   = ACC_W'(1) << (ACC_W - 2);
  localparam logic [ACC_W-1:0] LAG_W = ACC_W'(LAG);

  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  qnco_state_e      state_q, state_d;
  logic             err_q, err_d;
  logic [ACC_W-1:0] inc_q;
  logic             inc_ld;
  logic [LAG-1:0]   lag_q, lag_d;
  logic             div_load, div_last, acc_load, bad_req, running;
  logic [ACC_W-1:0] quot_nxt;
  logic [ACC_W-1:0] load_val [2];
  logic             step_en  [2];
  logic             wave     [2];

  qnco_div #(.W(ACC_W)) div_i (
    .clk        (clk),
    .rst_n      (rst_s2),
    .load       (div_load),
    .num        (tgt_freq),
    .den        (clk_freq),
    .last_o     (div_last),
    .quot_nxt_o (quot_nxt)
  );

  always_comb begin
    bad_req  = (clk_freq == '0) || ({tgt_freq, 2'b00} >= {2'b00, clk_freq});
    state_d  = state_q;
    err_d    = err_q;
    div_load = 1'b0;
    acc_load = 1'b0;
    inc_ld   = 1'b0;
    load_val[0] = '0;
    load_val[1] = '0;
    unique case (state_q)
      ST_IDLE, ST_RUN: begin
        if (start) begin
          acc_load = 1'b1;
          if (bad_req) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            err_d    = 1'b0;
            div_load = 1'b1;
            state_d  = ST_CALC;
          end
        end
      end
      ST_CALC: begin
        if (div_last) begin
          acc_load    = 1'b1;
          inc_ld      = 1'b1;
          load_val[1] = LAG_W * quot_nxt - QTR;
          state_d     = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (start) state_d = ST_RUN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign running = (state_q == ST_RUN);
  assign lag_d   = acc_load ? '0 : LAG'({lag_q, running});

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      lag_q   <= '0;
      inc_q   <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      lag_q   <= lag_d;
      if (inc_ld) inc_q <= quot_nxt;
    end
  end

  assign step_en[0] = running;
  assign step_en[1] = lag_q[LAG-1];

  for (genvar c = 0; c < 2; c++) begin : g_chan
    qnco_acc #(.W(ACC_W)) acc_i (
      .clk      (clk),
      .rst_n    (rst_s2),
      .load     (acc_load),
      .load_val (load_val[c]),
      .en       (step_en[c]),
      .inc      (inc_q),
      .msb_o    (wave[c])
    );
  end

  assign i_out = wave[0];
  assign q_out = wave[1];
  assign busy  = (state_q == ST_CALC);
  assign ready = (state_q == ST_HOLD);
  assign err   = err_q;
endmodule

// File: rtl/qnco_chk.sv
module qnco_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [ACC_W-1:0] tgt_freq,
  input logic [ACC_W-1:0] clk_freq,
  input logic             i_out,
  input logic             q_out,
  input logic             busy,
  input logic             ready,
  input logic             err
);
  logic [1:0] live_sr;
  logic [7:0] bcnt;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_sr <= '0;
      bcnt    <= '0;
    end else begin
      live_sr <= {live_sr[0], 1'b1};
      bcnt    <= busy ? bcnt + 1'b1 : 8'd0;
    end
  end
  assign live = live_sr[1];

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == 8'(ACC_W)) && ready);

  // R2
  busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ready) && !(err && (busy || ready)));

  // R5
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ready && $stable(i_out) && $stable(q_out));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start) |=> !ready && !busy && !i_out);

  // R8
  too_fast_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && start && !busy && !ready && (clk_freq != '0) &&
     ({tgt_freq, 2'b00} >= {2'b00, clk_freq}))
    |=> err && !busy && !ready && !i_out && !q_out);

  // R9
  zero_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && start && !busy && !ready && (clk_freq == '0))
    |=> err && !busy && !ready);
endmodule

bind quad_nco qnco_chk #(.ACC_W(ACC_W)) chk_i (.*);

// File: tb/quad_nco_tb_top.sv
`timescale 1ns/1ps
module quad_nco_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] tgt, cf;
  logic        i_out, q_out, busy, ready, err;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  quad_nco dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_freq(tgt), .clk_freq(cf),
    .i_out(i_out), .q_out(q_out), .busy(busy), .ready(ready), .err(err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic run_case(input logic [31:0] t, input logic [31:0] c, input bit mid);
    logic [31:0] inc, qld, ei, eq;
    logic [63:0] num;
    int n, ti, tq;
    bit pi, pq;
    real p, d;
    num = {t, 32'b0};
    inc = 32'(num / 64'(c));
    qld = inc * 32'd4 - 32'h4000_0000;
    @(negedge clk); tgt = t; cf = c; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2 busy rises", busy, 1);
    chk(err == 1'b0, "R10 err cleared", err, 0);
    n = 0;
    while (busy && n < 100) begin
      if (mid && n == 10) begin start = 1'b1; tgt = t + 32'd3; end
      else begin start = 1'b0; tgt = t; end
      n++;
      @(negedge clk);
    end
    start = 1'b0; tgt = t;
    chk(n == 32, mid ? "R3 busy length with extra start" : "R2 busy length", n, 32);
    chk(ready == 1'b1, "R2 ready after busy", ready, 1);
    chk(i_out == 1'b0, "R5 I frozen value", i_out, 0);
    chk(q_out == qld[31], "R5 Q frozen value", q_out, qld[31]);
    repeat (3) @(negedge clk);
    chk(ready && i_out == 1'b0 && q_out == qld[31], "R5 still frozen", {ready, i_out, q_out},
        {1'b1, 1'b0, qld[31]});
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(ready == 1'b0, "R6 ready drops on release", ready, 0);
    ti = -1; tq = -1; pi = 1'b0; pq = q_out;
    for (int m = 0; m < 400; m++) begin
      ei = inc * 32'(m);
      eq = qld + inc * 32'((m > 4) ? m - 4 : 0);
      chk(i_out == ei[31], mid ? "R3 R4 I phase" : "R4 R6 I phase", i_out, ei[31]);
      chk(q_out == eq[31], "R7 Q phase", q_out, eq[31]);
      if (m >= 8 && ti < 0 && i_out && !pi) ti = m;
      if (ti >= 0 && tq < 0 && m > ti && q_out && !pq) tq = m;
      pi = i_out; pq = q_out;
      @(negedge clk);
    end
    if (inc != 0) begin
      p = 4294967296.0 / real'(inc);
      d = real'(tq - ti) - p / 4.0;
      chk(tq > 0 && d <= 1.0 && d >= -1.0, "R7 quarter-period edge gap", tq - ti,
          longint'(p / 4.0));
    end
  endtask

  task automatic err_case(input logic [31:0] t, input logic [31:0] c, input string req);
    @(negedge clk); tgt = t; cf = c; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(err == 1'b1, req, err, 1);
    chk(!busy && !ready, req, {busy, ready}, 0);
    repeat (5) @(negedge clk);
    chk(!i_out && !q_out && err, req, {err, i_out, q_out}, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; tgt = '0; cf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk({i_out, q_out, busy, ready, err} == 5'b0, "R1 reset state",
        {i_out, q_out, busy, ready, err}, 0);
    run_case(32'd10, 32'd1000, 1'b0);
    run_case(32'd37, 32'd1000, 1'b1);
    run_case(32'd100, 32'd1000, 1'b0);      // R10 restart from running waves
    err_case(32'd250, 32'd1000, "R8 boundary refused");
    err_case(32'd1000, 32'd1000, "R8 above limit refused");
    err_case(32'd5, 32'd0, "R9 zero clock refused");
    run_case(32'd249, 32'd1000, 1'b0);      // R10 err cleared by valid start
    run_case(32'd30_000_000, 32'd250_000_000, 1'b0);
    run_case(32'd62_499_999, 32'd250_000_000, 1'b0);
    run_case(32'd0, 32'd1000, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule